// File: doc/BRIEF.md
# Windowed Pixel Memory Write Addresser

This block turns a stream of pixel data bytes into writes to a packed pixel memory of 80 rows by 64 bytes (5120 bytes; each byte carries two 4-bit pixels, so a row is 128 pixels wide). It keeps a column pointer and a row pointer. For every byte strobe it drives a write to the memory at `column + row * 64` in that same cycle, and it moves the pointers one step through a rectangular window that can be programmed.

The window is set by presenting column and row start/end bounds and pulsing a load input. That pulse also moves both pointers to the new start corner. A scan-order input picks how the pointers step. In horizontal order the column moves first. In vertical order the row moves first. Each axis wraps back to its start on its own. A dirty flag tells a scan-out engine that the memory has changed, and that engine clears the flag with a one-cycle acknowledge.

Command decoding sits upstream. This block only sees byte strobes, bounds, the load pulse and the scan-order bit.

Top module: `win_pixel_addr`

## Requirements
- R1: After reset the dirty flag is 0, no write is issued, both pointers are 0, and the window spans columns 0..63 and rows 0..79. The first byte is therefore written at address 0, and the 65th byte at address 64.
- R2: While `byte_vld` is 1, `mem_we` is 1 in that same cycle, `mem_wdata` equals `byte_in`, and `mem_addr` equals col + row*64 of the current pointers. When `byte_vld` is 0, `mem_we` is 0.
- R3: In horizontal order (`vert_mode` = 0), each write moves the column up by one. A write made at or past the column end sends the column back to the column start and moves the row up by one.
- R4: In vertical order (`vert_mode` = 1), each write moves the row up by one. A write made at or past the row end sends the row back to the row start and moves the column up by one.
- R5: When the outer axis is also at or past its end, it returns to its own start, so the write after the last cell of the window lands on the window's start corner.
- R6: A 1 on `win_load` latches the four bounds and sets the column pointer to `col_lo` and the row pointer to the row start. Row bounds of 80 or more are taken modulo 80. Column bounds are 6 bits and so always fall in 0..63.
- R7: Any write sets `dirty` on the next cycle. A `dirty_ack` with no write in the same cycle clears it. When a write and an acknowledge arrive in the same cycle, `dirty` stays 1.
- R8: When `win_load` and `byte_vld` are both 1 in the same cycle, the byte is written at the old pointer address. The pointers then take the new window start, and no step is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_vld | input | 1 | Pixel data byte strobe |
| byte_in | input | 8 | Pixel data byte (two 4-bit pixels) |
| win_load | input | 1 | Load the window bounds and move the pointers to the start corner |
| col_lo | input | 6 | Window column start |
| col_hi | input | 6 | Window column end |
| row_lo | input | 7 | Window row start (taken modulo 80) |
| row_hi | input | 7 | Window row end (taken modulo 80) |
| vert_mode | input | 1 | 0: column steps first, 1: row steps first |
| dirty_ack | input | 1 | Scan-out acknowledge; clears the dirty flag |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 13 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| dirty | output | 1 | Memory has changed since the last acknowledge |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a byte write and a dirty acknowledge. The bench strobes a byte with `dirty_ack` also high and expects `dirty` to stay 1. It then sends a lone acknowledge and expects `dirty` to drop. The second pair is a byte write and a window load. The bench strobes a byte together with `win_load` and expects the scoreboard to see that byte at the old pointer address. The next byte must land exactly on the new window's start corner, with no step applied.

// File: rtl/wpa_pkg.sv
// Package: shared types for the windowed pixel write addresser.
// Assumes nothing beyond standard SystemVerilog.
package wpa_pkg;
    // Pointer stepping order across the window.
    typedef enum logic {
        SCAN_HORIZ = 1'b0,
        SCAN_VERT  = 1'b1
    } scan_dir_e;
endpackage

// File: rtl/wpa_bounds.sv
// Window bound register: captures column/row start and end on a load
// pulse and folds row values into the row range. Assumes
// ROWS > 2**(ROW_W-1), so one subtraction is enough to fold any input.
module wpa_bounds #(
    parameter int COL_W = 6,
    parameter int ROW_W = 7,
    parameter int ROWS  = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [COL_W-1:0] col_lo_i,
    input  logic [COL_W-1:0] col_hi_i,
    input  logic [ROW_W-1:0] row_lo_i,
    input  logic [ROW_W-1:0] row_hi_i,
    output logic [ROW_W-1:0] row_lo_fold,
    output logic [COL_W-1:0] col_start,
    output logic [COL_W-1:0] col_end,
    output logic [ROW_W-1:0] row_start,
    output logic [ROW_W-1:0] row_end
);
    localparam logic [ROW_W-1:0] ROW_LIM  = ROW_W'(ROWS);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = '1;

    logic [ROW_W-1:0] row_hi_fold;

    // Fold row bounds into 0..ROWS-1.
    always_comb begin
        row_lo_fold = (row_lo_i >= ROW_LIM) ? row_lo_i - ROW_LIM : row_lo_i;
        row_hi_fold = (row_hi_i >= ROW_LIM) ? row_hi_i - ROW_LIM : row_hi_i;
    end

    // Hold the window; reset opens it to the full memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_start <= '0;
            col_end   <= COL_LAST;
            row_start <= '0;
            row_end   <= ROW_LAST;
        end else if (load) begin
            col_start <= col_lo_i;
            col_end   <= col_hi_i;
            row_start <= row_lo_fold;
            row_end   <= row_hi_fold;
        end
    end
endmodule

// File: rtl/wpa_axis.sv
// One window axis pointer: loads a start value, or steps by one and
// wraps to the start once it is at or past the end. A load has priority
// over a step. at_end tells the other axis when to carry.
module wpa_axis #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic [W-1:0] start_val,
    input  logic [W-1:0] end_val,
    output logic [W-1:0] ptr,
    output logic         at_end
);
    // Wrap condition for this axis.
    always_comb at_end = (ptr >= end_val);

    // Pointer update: load, else step-with-wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= at_end ? start_val : ptr + W'(1);
        end
    end
endmodule

// File: rtl/wpa_dirty.sv
// Redraw flag: set by any write, cleared by a scan-out acknowledge.
// A write in the same cycle as an acknowledge wins.
module wpa_dirty (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic ack,
    output logic dirty
);
    // Set/clear with write priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   dirty <= 1'b0;
        else if (wr)  dirty <= 1'b1;
        else if (ack) dirty <= 1'b0;
    end
endmodule

// File: rtl/win_pixel_addr.sv
// Top: windowed pixel memory write addresser. Issues a memory write in
// the same cycle as each byte strobe at col + row*ROW_BYTES, then steps
// the pointers through the programmed window in the chosen order.
// Assumes the memory accepts one write per cycle with no back-pressure.
module win_pixel_addr #(
    parameter int ROW_BYTES = 64,
    parameter int ROWS      = 80,
    parameter int DATA_W    = 8,
    localparam int COL_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = $clog2(ROWS),
    localparam int ADDR_W   = $clog2(ROW_BYTES * ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              win_load,
    input  logic [COL_W-1:0]  col_lo,
    input  logic [COL_W-1:0]  col_hi,
    input  logic [ROW_W-1:0]  row_lo,
    input  logic [ROW_W-1:0]  row_hi,
    input  logic              vert_mode,
    input  logic              dirty_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dirty
);
    import wpa_pkg::*;

    logic [COL_W-1:0] col_start_q, col_end_q, col_ptr;
    logic [ROW_W-1:0] row_start_q, row_end_q, row_ptr, row_lo_fold;
    logic             col_at_end, row_at_end;
    logic             col_step, row_step;
    scan_dir_e        dir;

    wpa_bounds #(.COL_W(COL_W), .ROW_W(ROW_W), .ROWS(ROWS)) u_bounds (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (win_load),
        .col_lo_i    (col_lo),
        .col_hi_i    (col_hi),
        .row_lo_i    (row_lo),
        .row_hi_i    (row_hi),
        .row_lo_fold (row_lo_fold),
        .col_start   (col_start_q),
        .col_end     (col_end_q),
        .row_start   (row_start_q),
        .row_end     (row_end_q)
    );

    // Choose which axis is inner; the outer one steps only on the inner wrap.
    always_comb begin
        dir = scan_dir_e'(vert_mode);
        if (dir == SCAN_VERT) begin
            row_step = byte_vld;
            col_step = byte_vld & row_at_end;
        end else begin
            col_step = byte_vld;
            row_step = byte_vld & col_at_end;
        end
    end

    wpa_axis #(.W(COL_W)) u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (win_load),
        .load_val  (col_lo),
        .step      (col_step),
        .start_val (col_start_q),
        .end_val   (col_end_q),
        .ptr       (col_ptr),
        .at_end    (col_at_end)
    );

    wpa_axis #(.W(ROW_W)) u_row (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (win_load),
        .load_val  (row_lo_fold),
        .step      (row_step),
        .start_val (row_start_q),
        .end_val   (row_end_q),
        .ptr       (row_ptr),
        .at_end    (row_at_end)
    );

    // Same-cycle memory write port from the current pointers.
    always_comb begin
        mem_we    = byte_vld;
        mem_wdata = byte_in;
        mem_addr  = ADDR_W'(row_ptr) * ADDR_W'(ROW_BYTES) + ADDR_W'(col_ptr);
    end

    wpa_dirty u_dirty (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (byte_vld),
        .ack   (dirty_ack),
        .dirty (dirty)
    );
endmodule

// File: rtl/wpa_checker.sv
// Checker: temporal properties of the windowed pixel write addresser,
// bound into every instance of the top module.
module wpa_checker #(
    parameter int COL_W = 6,
    parameter int ROW_W = 7,
    parameter int ROWS  = 80
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_vld,
    input logic             win_load,
    input logic             vert_mode,
    input logic             dirty_ack,
    input logic             dirty,
    input logic [COL_W-1:0] col_lo,
    input logic [COL_W-1:0] col_ptr,
    input logic [ROW_W-1:0] row_ptr,
    input logic [COL_W-1:0] col_end_q,
    input logic [ROW_W-1:0] row_end_q
);
    // R7
    write_sets_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> dirty);
    // R7
    ack_clears_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_ack && !byte_vld) |=> !dirty);
    // R6
    load_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_load |=> (col_ptr == $past(col_lo)));
    // R6
    row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_ptr < ROW_W'(ROWS));
    // R3
    horiz_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !win_load && !vert_mode && col_ptr < col_end_q)
        |=> (col_ptr == COL_W'($past(col_ptr) + 1'b1)) && $stable(row_ptr));
    // R4
    vert_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !win_load && vert_mode && row_ptr < row_end_q)
        |=> (row_ptr == ROW_W'($past(row_ptr) + 1'b1)) && $stable(col_ptr));
endmodule

bind win_pixel_addr wpa_checker #(.COL_W(COL_W), .ROW_W(ROW_W), .ROWS(ROWS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .win_load  (win_load),
    .vert_mode (vert_mode),
    .dirty_ack (dirty_ack),
    .dirty     (dirty),
    .col_lo    (col_lo),
    .col_ptr   (col_ptr),
    .row_ptr   (row_ptr),
    .col_end_q (col_end_q),
    .row_end_q (row_end_q)
);

// File: tb/sim_win_pixel_addr.sv
`timescale 1ns/1ps
module sim_win_pixel_addr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        win_load = 1'b0;
    logic [5:0]  col_lo = '0, col_hi = '0;
    logic [6:0]  row_lo = '0, row_hi = '0;
    logic        vert_mode = 1'b0;
    logic        dirty_ack = 1'b0;
    logic        mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        dirty;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Scoreboard queues of expected writes.
    logic [12:0] exp_a[$];
    logic [7:0]  exp_d[$];
    string       exp_t[$];

    // Bench model of the pointers and window, from the requirements.
    int m_col = 0, m_row = 0, m_cs = 0, m_ce = 63, m_rs = 0, m_re = 79;
    bit m_vert = 1'b0;

    always #2 clk = ~clk;

    win_pixel_addr u0 (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .win_load(win_load), .col_lo(col_lo), .col_hi(col_hi),
        .row_lo(row_lo), .row_hi(row_hi), .vert_mode(vert_mode),
        .dirty_ack(dirty_ack), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .dirty(dirty)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        if (!m_vert) begin
            if (m_col >= m_ce) begin
                m_col = m_cs;
                if (m_row >= m_re) m_row = m_rs; else m_row++;
            end else m_col++;
        end else begin
            if (m_row >= m_re) begin
                m_row = m_rs;
                if (m_col >= m_ce) m_col = m_cs; else m_col++;
            end else m_row++;
        end
    endtask

    // Driver: one byte (optionally with load and/or ack) in one cycle.
    task automatic drive(input logic [7:0] d, input bit ld, input int cl, input int ch,
                         input int rl, input int rh, input bit ack, input string tag);
        byte_vld = 1'b1; byte_in = d; dirty_ack = ack;
        win_load = ld;
        col_lo = 6'(cl); col_hi = 6'(ch); row_lo = 7'(rl); row_hi = 7'(rh);
        exp_a.push_back(13'(m_row * 64 + m_col));
        exp_d.push_back(d);
        exp_t.push_back(tag);
        if (ld) begin
            m_cs = cl % 64; m_ce = ch % 64; m_rs = rl % 80; m_re = rh % 80;
            m_col = m_cs; m_row = m_rs;
        end else model_step();
        @(posedge clk); #1;
        byte_vld = 1'b0; win_load = 1'b0; dirty_ack = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d, input string tag);
        drive(d, 1'b0, 0, 0, 0, 0, 1'b0, tag);
    endtask

    task automatic load_win(input int cl, input int ch, input int rl, input int rh);
        win_load = 1'b1;
        col_lo = 6'(cl); col_hi = 6'(ch); row_lo = 7'(rl); row_hi = 7'(rh);
        m_cs = cl % 64; m_ce = ch % 64; m_rs = rl % 80; m_re = rh % 80;
        m_col = m_cs; m_row = m_rs;
        @(posedge clk); #1;
        win_load = 1'b0;
    endtask

    // Monitor: pop and compare every write seen on the memory port.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_a.size() == 0) begin
                check(1'b0, "R2 unexpected write", int'(mem_addr), -1);
            end else begin
                automatic logic [12:0] ea = exp_a.pop_front();
                automatic logic [7:0]  ed = exp_d.pop_front();
                automatic string       et = exp_t.pop_front();
                check(mem_addr == ea, {et, " addr"}, int'(mem_addr), int'(ea));
                check(mem_wdata == ed, {"R2 data ", et}, int'(mem_wdata), int'(ed));
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        check(dirty == 1'b0, "R1 dirty after reset", int'(dirty), 0);
        check(mem_we == 1'b0, "R1 no write after reset", int'(mem_we), 0);
        @(posedge clk); #1;

        // R1/R2: first writes from the reset window
        wr(8'h11, "R1 first");
        check(dirty == 1'b1, "R7 dirty after write", int'(dirty), 1);
        wr(8'h22, "R2 second");
        wr(8'h33, "R2 third");

        // R7: lone acknowledge clears
        dirty_ack = 1'b1; @(posedge clk); #1; dirty_ack = 1'b0;
        check(dirty == 1'b0, "R7 ack clears", int'(dirty), 0);

        // R3/R5: horizontal wrap in a 2x2 window at the far corner
        m_vert = 1'b0; vert_mode = 1'b0;
        load_win(62, 63, 78, 79);
        check(dirty == 1'b0, "R6 load alone leaves dirty", int'(dirty), 0);
        for (int i = 0; i < 5; i++) wr(8'(8'h40 + i), "R3 horiz");

        // R4/R5: vertical order in a 2x3 window
        m_vert = 1'b1; vert_mode = 1'b1;
        load_win(2, 3, 1, 3);
        for (int i = 0; i < 7; i++) wr(8'(8'h60 + i), "R4 vert");

        // R6: row bounds above 79 are folded modulo 80
        m_vert = 1'b0; vert_mode = 1'b0;
        load_win(0, 1, 85, 90);
        for (int i = 0; i < 3; i++) wr(8'(8'h70 + i), "R6 fold");

        // R8: write and load in the same cycle
        drive(8'h80, 1'b1, 10, 12, 5, 6, 1'b0, "R8 old addr");
        wr(8'h81, "R8 new start");
        wr(8'h82, "R8 step");

        // R7: write with acknowledge in the same cycle keeps dirty set
        drive(8'h90, 1'b0, 0, 0, 0, 0, 1'b1, "R7 collide");
        check(dirty == 1'b1, "R7 write beats ack", int'(dirty), 1);
        dirty_ack = 1'b1; @(posedge clk); #1; dirty_ack = 1'b0;
        check(dirty == 1'b0, "R7 ack after collide", int'(dirty), 0);

        // R1/R5: full window sweep, then back to address 0
        load_win(0, 63, 0, 79);
        for (int i = 0; i < 5120; i++) wr(8'(i), "R5 sweep");
        wr(8'hA5, "R5 wrap to 0");

        @(posedge clk); #1;
        check(exp_a.size() == 0, "R2 all writes seen", exp_a.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule